// File: doc/BRIEF.md
# Free-Running Timer with Auto-Advancing Comparator

This block is a 64-bit up-counter that runs without stopping and sits behind a 32-bit register bus. A 64-bit comparator watches it. Software loads the comparator and sets the enables. Once the count reaches or passes the comparator, a sticky event flag sets. The interrupt line follows that flag whenever interrupts are enabled.

When auto-advance is on, the same cycle that sets the flag also adds a 32-bit step value to the comparator. Periodic interrupts therefore arrive without any software rewrite of the comparator. Software only has to acknowledge the flag.

An 8-bit prescale field slows the count by a whole-number factor. Because the count is wider than the bus, reading the low word also latches the high word. A later high-word read returns the latched value, so the two halves always belong to the same instant.

Top module: `gt_timer`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq_o` is low.
- R2: The register word index is `bus_addr[4:2]`: 0 count low, 1 count high, 2 control, 3 status, 4 comparator low, 5 comparator high, 6 step. Control holds run (bit 0), compare enable (bit 1), interrupt enable (bit 2), auto-advance (bit 3) and prescale (bits 15:8). All other control bits read as zero. The comparator and step words read back what was written.
- R3: While run is set, the count rises by one every (prescale+1) clock cycles; while run is clear it holds.
- R4: A write to either count word takes effect only while run is clear; a write while running is ignored.
- R5: The count is one 64-bit value: the low word carries into the high word.
- R6: A read of the count high word returns the high half captured at the most recent count-low read, not the live value.
- R7: When compare enable is set and the full 64-bit count is greater than or equal to the 64-bit comparator, status bit 0 is set on the next clock edge.
- R8: Writing 1 to status bit 0 clears it, unless a compare hit occurs in the same cycle; in that case the flag stays set.
- R9: With auto-advance set, each compare hit adds the step value to the comparator on the edge that sets the flag. Without auto-advance the comparator is unchanged.
- R10: `irq_o` is high exactly when status bit 0 is set and interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the addressed word |
| irq_o | output | 1 | Compare interrupt |

## Verification
The hardest situations to reach are those that depend on the exact number of cycles a running counter spends between bus accesses. These include the number of comparator advances in a run, the prescaler phase at stop time, and a count-high read that lags the live value by a carry.

The stimulus reaches them deterministically. It loads the count while stopped, starts it with a control write, and idles a fixed number of cycles. A second control write then freezes the count, and both count and comparator are read back.

The carry case starts the count one below a low-word wrap. The low word is then read on the very cycle before the carry, so the snapshot and the live high word differ.

// File: rtl/gt_pkg.sv
package gt_pkg;

    localparam int BUS_W = 32;
    localparam int PSC_W = 8;

    // word index taken from bus_addr[4:2]
    typedef enum logic [2:0] {
        W_CNT_LO = 3'd0,
        W_CNT_HI = 3'd1,
        W_CTRL   = 3'd2,
        W_STAT   = 3'd3,
        W_CMP_LO = 3'd4,
        W_CMP_HI = 3'd5,
        W_STEP   = 3'd6,
        W_NONE   = 3'd7
    } word_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             auto_adv;
        logic             irq_en;
        logic             cmp_en;
        logic             run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.run      = w[0];
        c.cmp_en   = w[1];
        c.irq_en   = w[2];
        c.auto_adv = w[3];
        c.psc      = w[8 +: PSC_W];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w            = '0;
        w[0]         = c.run;
        w[1]         = c.cmp_en;
        w[2]         = c.irq_en;
        w[3]         = c.auto_adv;
        w[8 +: PSC_W] = c.psc;
        return w;
    endfunction

endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] div_q;

    // >= keeps the divider sane if the limit is lowered mid-count
    assign tick = run && (div_q >= psc);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
    parameter int CNT_W = 64,
    parameter int BUS_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [BUS_W-1:0]   wdata,
    input  logic               snap,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W-BUS_W-1:0] snap_hi
);
    localparam int HI_W = CNT_W - BUS_W;

    logic [CNT_W-1:0] cnt_q;
    logic [HI_W-1:0]  snap_q;

    // writes are gated by the top to the stopped state, so they never meet a tick
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q[BUS_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cnt_q[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (snap) begin
            snap_q <= cnt_q[CNT_W-1:BUS_W];
        end
    end

    assign count   = cnt_q;
    assign snap_hi = snap_q;
endmodule

// File: rtl/gt_compare.sv
module gt_compare #(
    parameter int CNT_W = 64,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic             cmp_en,
    input  logic             auto_adv,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_step,
    input  logic             clr,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] cmp,
    output logic [BUS_W-1:0] step,
    output logic             match,
    output logic             flag
);
    localparam int HI_W = CNT_W - BUS_W;

    logic [CNT_W-1:0] cmp_q;
    logic [BUS_W-1:0] step_q;
    logic             flag_q;
    logic [CNT_W-1:0] cmp_next;

    assign match    = cmp_en && (count >= cmp_q);
    assign cmp_next = cmp_q + {{HI_W{1'b0}}, step_q};

    // a bus write to the comparator beats the automatic advance
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (wr_lo) begin
            cmp_q[BUS_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cmp_q[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
        end else if (match && auto_adv) begin
            cmp_q <= cmp_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (wr_step) begin
            step_q <= wdata;
        end
    end

    // set has priority over the write-one clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign cmp  = cmp_q;
    assign step = step_q;
    assign flag = flag_q;
endmodule

// File: rtl/gt_timer.sv
module gt_timer
    import gt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam int HI_W = CNT_W - BUS_W;

    ctrl_t            ctrl_q;
    word_e            widx;
    logic             wr, rd;
    logic             tick;
    logic             cnt_wr_lo, cnt_wr_hi;
    logic             cmp_wr_lo, cmp_wr_hi, step_wr, sts_clr, lo_rd;
    logic [CNT_W-1:0] count_q;
    logic [HI_W-1:0]  snap_hi;
    logic [CNT_W-1:0] cmp_q;
    logic [BUS_W-1:0] step_q;
    logic             match, flag_q;

    // address bits above the register window must be zero
    generate
        if (ADDR_W > 5) begin : g_wide_addr
            logic hi_zero;
            assign hi_zero = (bus_addr[ADDR_W-1:5] == '0);
            assign widx    = hi_zero ? word_e'(bus_addr[4:2]) : W_NONE;
        end else begin : g_exact_addr
            assign widx = word_e'(bus_addr[4:2]);
        end
    endgenerate

    assign wr = bus_en && bus_we;
    assign rd = bus_en && !bus_we;

    assign cnt_wr_lo = wr && (widx == W_CNT_LO) && !ctrl_q.run;
    assign cnt_wr_hi = wr && (widx == W_CNT_HI) && !ctrl_q.run;
    assign cmp_wr_lo = wr && (widx == W_CMP_LO);
    assign cmp_wr_hi = wr && (widx == W_CMP_HI);
    assign step_wr   = wr && (widx == W_STEP);
    assign sts_clr   = wr && (widx == W_STAT) && bus_wdata[0];
    assign lo_rd     = rd && (widx == W_CNT_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr && (widx == W_CTRL)) begin
            ctrl_q <= ctrl_from_word(bus_wdata);
        end
    end

    gt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .psc  (ctrl_q.psc),
        .tick (tick)
    );

    gt_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_lo   (cnt_wr_lo),
        .wr_hi   (cnt_wr_hi),
        .wdata   (bus_wdata),
        .snap    (lo_rd),
        .count   (count_q),
        .snap_hi (snap_hi)
    );

    gt_compare #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .count    (count_q),
        .cmp_en   (ctrl_q.cmp_en),
        .auto_adv (ctrl_q.auto_adv),
        .wr_lo    (cmp_wr_lo),
        .wr_hi    (cmp_wr_hi),
        .wr_step  (step_wr),
        .clr      (sts_clr),
        .wdata    (bus_wdata),
        .cmp      (cmp_q),
        .step     (step_q),
        .match    (match),
        .flag     (flag_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (widx)
            W_CNT_LO: bus_rdata = count_q[BUS_W-1:0];
            W_CNT_HI: bus_rdata[HI_W-1:0] = snap_hi;
            W_CTRL:   bus_rdata = ctrl_to_word(ctrl_q);
            W_STAT:   bus_rdata[0] = flag_q;
            W_CMP_LO: bus_rdata = cmp_q[BUS_W-1:0];
            W_CMP_HI: bus_rdata[HI_W-1:0] = cmp_q[CNT_W-1:BUS_W];
            W_STEP:   bus_rdata = step_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/gt_timer_chk.sv
module gt_timer_chk #(
    parameter int CNT_W = 64,
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cnt_wr_lo,
    input logic             cnt_wr_hi,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-BUS_W-1:0] snap_hi,
    input logic             lo_rd,
    input logic [CNT_W-1:0] cmp_q,
    input logic [BUS_W-1:0] step_q,
    input logic             cmp_wr_lo,
    input logic             cmp_wr_hi,
    input logic             match,
    input logic             auto_adv,
    input logic             flag_q,
    input logic             sts_clr,
    input logic             irq_en,
    input logic             irq_o
);
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count_q == $past(count_q) + 1'b1));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(count_q));

    // R6
    snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> (snap_hi == $past(count_q[CNT_W-1:BUS_W])));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> flag_q);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !sts_clr) |=> flag_q);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_clr && !match) |=> !flag_q);

    // R9
    cmp_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (match && auto_adv && !cmp_wr_lo && !cmp_wr_hi)
        |=> (cmp_q == $past(cmp_q) + {{(CNT_W-BUS_W){1'b0}}, $past(step_q)}));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq_o);
endmodule

bind gt_timer gt_timer_chk #(.CNT_W(CNT_W), .BUS_W(gt_pkg::BUS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_wr_lo (cnt_wr_lo),
    .cnt_wr_hi (cnt_wr_hi),
    .count_q   (count_q),
    .snap_hi   (snap_hi),
    .lo_rd     (lo_rd),
    .cmp_q     (cmp_q),
    .step_q    (step_q),
    .cmp_wr_lo (cmp_wr_lo),
    .cmp_wr_hi (cmp_wr_hi),
    .match     (match),
    .auto_adv  (ctrl_q.auto_adv),
    .flag_q    (flag_q),
    .sts_clr   (sts_clr),
    .irq_en    (ctrl_q.irq_en),
    .irq_o     (irq_o)
);

// File: tb/gt_timer_tb.sv
module gt_timer_tb;

    localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
                           A_STS = 5'h0C, A_MLO = 5'h10, A_MHI = 5'h14,
                           A_STP = 5'h18;

    typedef struct packed {
        logic        we;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b1, A_CLO, 32'h10,        32'h0,   1'b0, 4'd4},  // R4 stopped write
        '{1'b1, A_CHI, 32'h2,         32'h0,   1'b0, 4'd4},
        '{1'b0, A_CLO, 32'h0,         32'h10,  1'b0, 4'd4},  // R4
        '{1'b0, A_CHI, 32'h0,         32'h2,   1'b0, 4'd6},  // R6
        '{1'b1, A_MLO, 32'h20,        32'h0,   1'b0, 4'd2},
        '{1'b1, A_MHI, 32'h2,         32'h0,   1'b0, 4'd2},
        '{1'b0, A_MLO, 32'h0,         32'h20,  1'b0, 4'd2},  // R2
        '{1'b0, A_MHI, 32'h0,         32'h2,   1'b0, 4'd2},  // R2
        '{1'b1, A_STP, 32'h8,         32'h0,   1'b0, 4'd2},
        '{1'b0, A_STP, 32'h0,         32'h8,   1'b0, 4'd2},  // R2
        '{1'b1, A_CTL, 32'hFFFF_03F2, 32'h0,   1'b0, 4'd2},
        '{1'b0, A_CTL, 32'h0,         32'h302, 1'b0, 4'd2},  // R2 reserved bits
        '{1'b0, A_STS, 32'h0,         32'h0,   1'b0, 4'd7},  // R7 below
        '{1'b1, A_MLO, 32'h10,        32'h0,   1'b0, 4'd7},
        '{1'b0, A_CTL, 32'h0,         32'h302, 1'b0, 4'd7},
        '{1'b0, A_STS, 32'h0,         32'h1,   1'b0, 4'd7},  // R7 equal
        '{1'b1, A_CTL, 32'h306,       32'h0,   1'b0, 4'd10}, // R10 masked
        '{1'b0, A_STS, 32'h0,         32'h1,   1'b1, 4'd10}, // R10
        '{1'b1, A_STS, 32'h1,         32'h0,   1'b1, 4'd8},
        '{1'b0, A_STS, 32'h0,         32'h1,   1'b1, 4'd8},  // R8 set wins
        '{1'b1, A_CTL, 32'h304,       32'h0,   1'b1, 4'd8},
        '{1'b1, A_STS, 32'h1,         32'h0,   1'b1, 4'd8},
        '{1'b0, A_STS, 32'h0,         32'h0,   1'b0, 4'd8}   // R8 cleared
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gt_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // one bus access; read data and irq are sampled mid-cycle, before the edge
    task automatic access(input logic we, input logic [4:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic ir);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        rd = bus_rdata;
        ir = irq_o;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] r; logic i;
        access(1'b1, a, d, r, i);
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] r; logic i;
        access(1'b0, a, 32'h0, r, i);
        check(tag, r, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] r;
        logic        i;

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state is visible while reset is still held, then after release
        check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        rd_chk(A_CLO, 32'h0, "R1 count lo");
        rd_chk(A_CHI, 32'h0, "R1 count hi");
        rd_chk(A_CTL, 32'h0, "R1 control");
        rd_chk(A_STS, 32'h0, "R1 status");
        rd_chk(A_MLO, 32'h0, "R1 cmp lo");
        rd_chk(A_MHI, 32'h0, "R1 cmp hi");
        rd_chk(A_STP, 32'h0, "R1 step");

        // table walk: register map, compare, status and interrupt
        for (int v = 0; v < NV; v++) begin
            access(VEC[v].we, VEC[v].addr, VEC[v].data, r, i);
            if (!VEC[v].we)
                check($sformatf("R%0d vector %0d rdata", VEC[v].req, v), r, VEC[v].exp);
            check($sformatf("R%0d vector %0d irq", VEC[v].req, v), {31'b0, i}, {31'b0, VEC[v].exp_irq});
        end

        // R9 auto-advance: count 0..20, cmp 5 step 4 -> advances at counts 5,9,13,17
        wr(A_CTL, 32'h0);
        wr(A_CLO, 32'h0);
        wr(A_CHI, 32'h0);
        wr(A_MLO, 32'h5);
        wr(A_MHI, 32'h0);
        wr(A_STP, 32'h4);
        wr(A_STS, 32'h1);
        wr(A_CTL, 32'h0F);
        idle(19);
        wr(A_CTL, 32'h0E);
        rd_chk(A_CNT_LO_ADDR(), 32'd20, "R3 count after run");
        rd_chk(A_MLO, 32'd21, "R9 cmp advanced four times");
        rd_chk(A_MHI, 32'd0, "R9 cmp hi");
        rd_chk(A_STS, 32'h1, "R9 flag set by hits");

        // R9 without auto-advance the comparator stays put
        wr(A_STS, 32'h1);
        rd_chk(A_STS, 32'h0, "R8 clear with no hit");
        wr(A_CTL, 32'h03);
        idle(4);
        wr(A_CTL, 32'h02);
        rd_chk(A_CLO, 32'd25, "R3 count 20+5");
        rd_chk(A_MLO, 32'd21, "R9 cmp unchanged");
        rd_chk(A_STS, 32'h1, "R7 count above cmp");
        wr(A_STS, 32'h1);
        rd_chk(A_STS, 32'h1, "R8 hit beats clear");

        // R3 prescale 2: one step per three cycles
        wr(A_CTL, 32'h0);
        wr(A_CLO, 32'h0);
        wr(A_CHI, 32'h0);
        wr(A_CTL, 32'h0201);
        idle(10);
        wr(A_CTL, 32'h0);
        rd_chk(A_CLO, 32'd3, "R3 prescaled count");

        // R4 count writes while running are dropped
        wr(A_CLO, 32'h100);
        wr(A_CHI, 32'h0);
        wr(A_CTL, 32'h01);
        wr(A_CLO, 32'hABCD);
        wr(A_CHI, 32'h55);
        wr(A_CTL, 32'h0);
        rd_chk(A_CLO, 32'h103, "R4 lo write ignored");
        rd_chk(A_CHI, 32'h0, "R4 hi write ignored");

        // R5 carry and R6 snapshot
        wr(A_CLO, 32'hFFFF_FFFF);
        wr(A_CHI, 32'h1);
        wr(A_CTL, 32'h01);
        rd_chk(A_CLO, 32'hFFFF_FFFF, "R6 lo before carry");
        rd_chk(A_CHI, 32'h1, "R6 hi is snapshot");
        wr(A_CTL, 32'h0);
        rd_chk(A_CHI, 32'h1, "R6 snapshot held without lo read");
        rd_chk(A_CLO, 32'h2, "R5 lo after carry");
        rd_chk(A_CHI, 32'h2, "R5 hi carried");

        // R7 full-width compare: count 1_00000000 vs cmp 0_FFFFFFFF
        wr(A_STS, 32'h1);
        wr(A_CLO, 32'h0);
        wr(A_CHI, 32'h1);
        wr(A_MLO, 32'hFFFF_FFFF);
        wr(A_MHI, 32'h0);
        wr(A_CTL, 32'h02);
        rd_chk(A_STS, 32'h0, "R7 one edge of latency");
        access(1'b0, A_STS, 32'h0, r, i);
        check("R7 high word decides", r, 32'h1);
        check("R10 irq off while disabled", {31'b0, i}, 32'h0);

        report();
    end

    function automatic logic [4:0] A_CNT_LO_ADDR();
        return A_CLO;
    endfunction

endmodule